// File: doc/BRIEF.md
# Ten-Bit Word Serializer with Loopback Steering

This block turns a stream of 10-bit, already line-coded words into a serial NRZ bit stream at ten times the word rate. The design runs on a single bit-rate clock. A one-cycle word strobe stands in for the rising edge of the word-rate reference clock, and it captures the parallel input into a holding register. An internal bit counter marks the word boundary. On the bit period after the last bit of a word, the holding register moves into the shift register, so words follow each other with no idle bit between them.

A loopback select steers the serial stream. In normal mode the stream drives the line output, and the receive-side bit output passes the external line input through. In loopback mode the line output is parked at a constant 0 and the serial stream is sent to the receive-side bit output in its place. The select is registered only at word boundaries, so a word is never split across the two paths. The `word_take` output is high in the last bit period of each word. A word source uses it to place its strobe in the right slot.

Top module: `ser10_loop`

## Requirements
- R1: A word present on `tx_word` in a cycle where `word_stb` is high is captured. It is serialized starting in the bit period that follows the next clock edge at which `word_take` is high.
- R2: `word_take` is high for exactly one cycle in every ten. It is first high in the tenth cycle after reset release.
- R3: Bits of a word appear on the serial stream least-significant first: `tx_word[0]` first and `tx_word[9]` last, one bit per clock.
- R4: A new word starts in the bit period right after bit 9 of the previous word, so two words written in consecutive word slots come out with no gap.
- R5: While loopback is in effect, `line_tx` is held at 0.
- R6: While loopback is in effect, `rx_bit` carries the serial stream in the same order and timing that `line_tx` would have.
- R7: While loopback is not in effect, `line_tx` carries the serial stream and `rx_bit` equals `line_rx` in the same cycle.
- R8: `loop_en` is registered only at the edge where `word_take` is high. A change of `loop_en` in the middle of a word has no effect on that word.
- R9: Reset clears the holding register, the shift register and the loopback state. During reset and for the first word after it, `line_tx` is 0, and `word_take` is low during reset.
- R10: If no strobe arrives during a word slot, the most recently captured word is sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_stb | input | 1 | Word clock edge marker; captures `tx_word` |
| tx_word | input | 10 | Pre-encoded parallel word, bit 0 sent first |
| loop_en | input | 1 | Loopback request, taken at word boundaries |
| line_rx | input | 1 | Serial data from the external line |
| line_tx | output | 1 | Serial data to the external line |
| rx_bit | output | 1 | Serial data toward the receiver |
| word_take | output | 1 | High in the last bit period of each word |

## Verification
The hardest case to reach from the ports is a change of the loopback request in the middle of a word. The bench flips `loop_en` after the fifth bit of a word in both directions. It then checks that the rest of that word stays on the path chosen at the boundary, and that the next word moves to the new path. Back-to-back words are tested by strobing the following word while the current one is still shifting out. The bench then checks the twenty bits in a row across the boundary.

// File: rtl/ser10_loop.sv
module ser10_loop #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              loop_en,
  input  logic              line_rx,
  output logic              line_tx,
  output logic              rx_bit,
  output logic              word_take
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     pos;
  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] shreg;
  logic              loop_q;

  assign word_take = (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (word_stb) begin
      hold <= tx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      shreg  <= '0;
      loop_q <= 1'b0;
    end else if (word_take) begin
      pos    <= '0;
      shreg  <= hold;
      loop_q <= loop_en;
    end else begin
      pos    <= pos + CW'(1);
      shreg  <= {1'b0, shreg[WORD_W-1:1]};
    end
  end

  assign line_tx = loop_q ? 1'b0 : shreg[0];
  assign rx_bit  = loop_q ? shreg[0] : line_rx;
endmodule

module ser10_loop_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_take,
  input logic              loop_q,
  input logic              line_tx,
  input logic [WORD_W-1:0] shreg,
  input logic [WORD_W-1:0] hold
);
  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 0;
    else if (word_take) gap <= 0;
    else gap <= gap + 1;
  end

  // R2
  take_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> gap == WORD_W - 1);

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |=> shreg == $past(hold));

  // R3
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_take |=> shreg[WORD_W-2:0] == $past(shreg[WORD_W-1:1]));

  // R8
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_take |=> $stable(loop_q));

  // R5
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && $past(loop_q)) |-> ($stable(line_tx) && line_tx == 1'b0));
endmodule

bind ser10_loop ser10_loop_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_take(word_take), .loop_q(loop_q),
  .line_tx(line_tx), .shreg(shreg), .hold(hold)
);

// File: tb/sim_ser10_loop.sv
module sim_ser10_loop;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_stb = 1'b0;
  logic [9:0] tx_word = '0;
  logic       loop_en = 1'b0;
  logic       line_rx = 1'b0;
  logic       line_tx, rx_bit, word_take;
  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  ser10_loop u0 (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .tx_word(tx_word),
    .loop_en(loop_en), .line_rx(line_rx), .line_tx(line_tx),
    .rx_bit(rx_bit), .word_take(word_take)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input logic [9:0] w);
    while (!word_take) @(negedge clk);
    word_stb = 1'b1;
    tx_word  = w;
    @(negedge clk);
    word_stb = 1'b0;
  endtask

  // lp: path expected for this word; flip: toggle loop_en mid-word (R8)
  // nxt_on: strobe the next word during this one (R4)
  task automatic observe(input logic [9:0] w, input logic lp, input logic flip,
                         input logic nxt_on, input logic [9:0] nxt);
    while (!word_take) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      line_rx = ~w[i] ^ i[0];
      #0.5;
      if (lp) begin
        chk("R5", line_tx, 1'b0);
        chk("R6", rx_bit, w[i]);
      end else begin
        chk("R3", line_tx, w[i]);
        chk("R7", rx_bit, line_rx);
      end
      chk("R2", word_take, (i == 9));
      if (flip && i == 4) loop_en = ~loop_en;
      if (nxt_on && i == 3) begin word_stb = 1'b1; tx_word = nxt; end
      if (nxt_on && i == 4) word_stb = 1'b0;
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R9", line_tx, 1'b0);
    chk("R9", word_take, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9", line_tx, 1'b0);
    chk("R9", word_take, 1'b0);
    rst_n = 1'b1;
    observe(10'h000, 1'b0, 1'b0, 1'b0, 10'h000);
  endtask

  task automatic t_normal;
    load(10'h17C);
    observe(10'h17C, 1'b0, 1'b0, 1'b0, 10'h000);
    load(10'h2A5);
    observe(10'h2A5, 1'b0, 1'b0, 1'b0, 10'h000);
  endtask

  task automatic t_repeat;
    // R10: no strobe, same word again
    observe(10'h2A5, 1'b0, 1'b0, 1'b0, 10'h000);
  endtask

  task automatic t_back2back;
    // R4 / R1: next word strobed during current, no gap
    load(10'h0F3);
    observe(10'h0F3, 1'b0, 1'b0, 1'b1, 10'h30C);
    observe(10'h30C, 1'b0, 1'b0, 1'b1, 10'h155);
    observe(10'h155, 1'b0, 1'b0, 1'b0, 10'h000);
  endtask

  task automatic t_loop;
    loop_en = 1'b1;
    load(10'h1E6);
    observe(10'h1E6, 1'b1, 1'b0, 1'b1, 10'h3FF);
    observe(10'h3FF, 1'b1, 1'b0, 1'b0, 10'h000);
  endtask

  task automatic t_midflip;
    // R8: loop_en toggled mid-word, takes effect only next word
    load(10'h249);
    observe(10'h249, 1'b1, 1'b1, 1'b1, 10'h0B6);
    observe(10'h0B6, 1'b0, 1'b1, 1'b0, 10'h000);
    observe(10'h0B6, 1'b1, 1'b0, 1'b0, 10'h000);
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_repeat();
    t_back2back();
    t_loop();
    t_midflip();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule